// File: doc/BRIEF.md
# Priority-Resolved Pin Function Multiplexer

This block decides, for every multi-function pin of a chip, which of its signals is routed to the pad. Each pin has up to five ordered signal levels and a final fallback signal. A level is enabled by an OR of expressions. Each expression is an AND of descriptors, and each descriptor masks one source word, shifts the result down by the lowest set bit of the mask, and compares it with an enable value. A source word is either one of the writable control registers or the strap word. The strap word is captured once from the strap input after reset and cannot be written. The lowest-numbered enabled level wins. The fallback code appears only when no level is enabled. The fallback signal need not be GPIO, and GPIO can sit at a numbered level with its own expression.

Software programs the control registers through a simple write port and reads them back through a combinational read port. The chosen signal of each pin leaves the block as a registered index. The pin table is held as a constant function in the package, so the same logic serves any table of pins, levels, expressions and descriptors.

A two-state sequencer captures the strap word. Reset puts it in `ST_SAMPLE`. On the first clock after reset it takes the transition "capture" to `ST_HOLD`, loading the strap input into the strap word. `ST_HOLD` has a single transition, "stay", back to itself, so the strap word is frozen until the next reset.

Top module: `pin_func_mux`

## Requirements
- R1: While reset is asserted, every control register reads zero and every pin outputs the fallback code 5. On the first clock after reset the sequencer leaves `ST_SAMPLE`, captures the strap input, and remains in `ST_HOLD` until the next reset.
- R2: A write with `wr_en` high to an address from 0 to 2 loads `wr_data` into that control register at the clock edge. `rd_data` returns the addressed word combinationally.
- R3: Address 3 reads the captured strap word. A write to address 3 has no effect. A change on `strap_i` after the capture also has no effect.
- R4: Each pin's output is registered. It shows the new selection on the second clock edge after a write is presented: one edge for the register and one for the output. After the first edge it still shows the old selection.
- R5: Each pin output is a 3-bit code in field `sel_o[3*p+2:3*p]`. Codes 0 to 4 name the winning level, with 0 the highest priority. Code 5 means the fallback signal. When several levels are enabled, the lowest-numbered one is shown.
- R6: Pin 0 selects level 0 when ctrl0 bit 3 = 1, ctrl1 bit 15 = 1 and ctrl2 bit 31 = 0. It selects level 1 when the same two bits are set and ctrl2 bit 31 = 1. Otherwise it selects the fallback.
- R7: Pin 1 selects level 0 when ctrl1 bit 12 = 1 OR strap bit 14 = 1. It shows the fallback only when both are false.
- R8: Pin 2 selects level 0 when the 2-bit mode field ctrl2[5:4] is nonzero AND ctrl1 bit 17 = 1. It selects level 1 when ctrl1 bit 17 = 1 and the mode field is 0. Otherwise it selects the fallback.
- R9: Pin 3 checks five levels in this order:
  - level 0: ctrl0 bit 0 = 1
  - level 1: ctrl0 bit 1 = 1
  - level 2: ctrl2[5:4] = 3 and ctrl1 bit 22 = 1
  - level 3: ctrl1 bit 22 = 1
  - level 4: strap bit 6 = 0 and ctrl0 bit 2 = 1
  - otherwise: the fallback

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Write address; 0 to 2 are control registers, 3 is the strap word |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (2) | Read address |
| rd_data | output | DATA_W (32) | Read data, combinational |
| strap_i | input | DATA_W (32) | Strap input, captured once after reset |
| sel_o | output | NUM_PINS*SEL_W (12) | Selected signal code per pin, 3 bits per pin |

## Verification
On every cycle, the assertions check four things:
- a write lands in the addressed control register;
- the strap word never moves once the sequencer is in `ST_HOLD`, and the sequencer never leaves `ST_HOLD`;
- the pin outputs do not change when the register state did not change;
- no pin ever shows a code above the fallback.

The actual selection logic can only be shown by the bench. This covers the descriptor compares, AND within an expression, OR across expressions, and priority among levels. The bench compares each pin against its own reference evaluator after directed writes and random writes, under two strap values. The directed writes enable every level at once, vary the mode field, and flip the bits that must be zero.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    localparam int CFG_W     = 32;
    localparam int SRC_IDX_W = 3;

    typedef struct packed {
        logic                 used;
        logic [SRC_IDX_W-1:0] src;
        logic [CFG_W-1:0]     mask;
        logic [CFG_W-1:0]     val;
    } desc_t;

    function automatic desc_t mk(int src, logic [CFG_W-1:0] mask, logic [CFG_W-1:0] val);
        desc_t d;
        d.used = 1'b1;
        d.src  = SRC_IDX_W'(src);
        d.mask = mask;
        d.val  = val;
        return d;
    endfunction

    // Key layout: pin*1000 + level*100 + expression*10 + descriptor.
    // Source 0..2 are control registers, source 3 is the strap word.
    // Expressions fill their descriptors from slot 0 upward.
    function automatic desc_t pfm_desc(int pin, int lvl, int ex, int d);
        desc_t r;
        r = '0;
        case (pin * 1000 + lvl * 100 + ex * 10 + d)
            // pin 0: three-way AND, one bit must be clear for level 0
            0:    r = mk(0, 32'h0000_0008, 32'd1);
            1:    r = mk(1, 32'h0000_8000, 32'd1);
            2:    r = mk(2, 32'h8000_0000, 32'd0);
            100:  r = mk(0, 32'h0000_0008, 32'd1);
            101:  r = mk(1, 32'h0000_8000, 32'd1);
            102:  r = mk(2, 32'h8000_0000, 32'd1);
            // pin 1: two independent expressions, one on the strap word
            1000: r = mk(1, 32'h0000_1000, 32'd1);
            1010: r = mk(3, 32'h0000_4000, 32'd1);
            // pin 2: nonzero mode field spelled as three products, shared enable
            2000: r = mk(2, 32'h0000_0030, 32'd1);
            2001: r = mk(1, 32'h0002_0000, 32'd1);
            2010: r = mk(2, 32'h0000_0030, 32'd2);
            2011: r = mk(1, 32'h0002_0000, 32'd1);
            2020: r = mk(2, 32'h0000_0030, 32'd3);
            2021: r = mk(1, 32'h0002_0000, 32'd1);
            2100: r = mk(1, 32'h0002_0000, 32'd1);
            // pin 3: five levels
            3000: r = mk(0, 32'h0000_0001, 32'd1);
            3100: r = mk(0, 32'h0000_0002, 32'd1);
            3200: r = mk(2, 32'h0000_0030, 32'd3);
            3201: r = mk(1, 32'h0040_0000, 32'd1);
            3300: r = mk(1, 32'h0040_0000, 32'd1);
            3400: r = mk(3, 32'h0000_0040, 32'd0);
            3401: r = mk(0, 32'h0000_0004, 32'd1);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic bit expr_used(int pin, int lvl, int ex);
        desc_t d;
        d = pfm_desc(pin, lvl, ex, 0);
        return d.used;
    endfunction

    function automatic int low_bit(logic [CFG_W-1:0] m);
        int r;
        r = 0;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/pfm_regfile.sv
module pfm_regfile #(
    parameter int NUM_REGS = 3,
    parameter int DATA_W   = pfm_pkg::CFG_W,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1),
    parameter int NUM_SRC  = NUM_REGS + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic [DATA_W-1:0]         strap_i,
    output logic [NUM_SRC*DATA_W-1:0] src_flat,
    output logic                      strap_locked
);

    typedef enum logic [0:0] {
        ST_SAMPLE = 1'b0,
        ST_HOLD   = 1'b1
    } cap_state_e;

    cap_state_e        state_q, state_d;
    logic              cap_en;
    logic [DATA_W-1:0] strap_q;
    logic [DATA_W-1:0] ctrl_q [NUM_REGS];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SAMPLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cap_en  = 1'b0;
        unique case (state_q)
            ST_SAMPLE: begin
                cap_en  = 1'b1;
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                state_d = ST_HOLD;
            end
            default: state_d = ST_SAMPLE;
        endcase
    end

    assign strap_locked = (state_q == ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      strap_q <= '0;
        else if (cap_en) strap_q <= strap_i;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[r] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(r))
                ctrl_q[r] <= wr_data;
        end
        assign src_flat[r*DATA_W +: DATA_W] = ctrl_q[r];
    end
    assign src_flat[NUM_REGS*DATA_W +: DATA_W] = strap_q;

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_addr == ADDR_W'(r)) rd_data = ctrl_q[r];
        end
        if (rd_addr == ADDR_W'(NUM_REGS)) rd_data = strap_q;
    end

endmodule

// File: rtl/pfm_level_eval.sv
module pfm_level_eval #(
    parameter int PIN        = 0,
    parameter int NUM_LEVELS = 5,
    parameter int NUM_EXPR   = 3,
    parameter int NUM_DESC   = 3,
    parameter int NUM_SRC    = 4,
    parameter int DATA_W     = pfm_pkg::CFG_W
) (
    input  logic [NUM_SRC*DATA_W-1:0] src_flat,
    output logic [NUM_LEVELS-1:0]     lvl_en
);

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        logic [NUM_EXPR-1:0] ex_true;
        for (genvar e = 0; e < NUM_EXPR; e++) begin : g_ex
            localparam bit EX_USED = pfm_pkg::expr_used(PIN, l, e);
            logic [NUM_DESC-1:0] hit;
            for (genvar k = 0; k < NUM_DESC; k++) begin : g_desc
                localparam pfm_pkg::desc_t D = pfm_pkg::pfm_desc(PIN, l, e, k);
                localparam int SH  = pfm_pkg::low_bit(D.mask);
                localparam int SRC = int'(D.src);
                if (D.used && SRC < NUM_SRC) begin : g_cmp
                    assign hit[k] = ((src_flat[SRC*DATA_W +: DATA_W] & D.mask[DATA_W-1:0]) >> SH)
                                    == D.val[DATA_W-1:0];
                end else begin : g_free
                    assign hit[k] = 1'b1;
                end
            end
            assign ex_true[e] = EX_USED && (&hit);
        end
        assign lvl_en[l] = |ex_true;
    end

endmodule

// File: rtl/pfm_prio_pick.sv
module pfm_prio_pick #(
    parameter int NUM_LEVELS = 5,
    parameter int SEL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] lvl_en,
    output logic [SEL_W-1:0]      sel_q
);

    localparam logic [SEL_W-1:0] FALLBACK = SEL_W'(NUM_LEVELS);

    logic [SEL_W-1:0] sel_d;

    always_comb begin
        sel_d = FALLBACK;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (lvl_en[l]) sel_d = SEL_W'(l);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= FALLBACK;
        else        sel_q <= sel_d;
    end

endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux #(
    parameter int NUM_PINS   = 4,
    parameter int NUM_LEVELS = 5,
    parameter int NUM_EXPR   = 3,
    parameter int NUM_DESC   = 3,
    parameter int NUM_REGS   = 3,
    parameter int DATA_W     = pfm_pkg::CFG_W,
    parameter int ADDR_W     = $clog2(NUM_REGS + 1),
    parameter int SEL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic [DATA_W-1:0]         strap_i,
    output logic [NUM_PINS*SEL_W-1:0] sel_o
);

    localparam int NUM_SRC = NUM_REGS + 1;

    logic [NUM_SRC*DATA_W-1:0] src_flat;
    logic                      strap_locked;

    pfm_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_SRC  (NUM_SRC)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .strap_i      (strap_i),
        .src_flat     (src_flat),
        .strap_locked (strap_locked)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [NUM_LEVELS-1:0] lvl_en;

        pfm_level_eval #(
            .PIN        (p),
            .NUM_LEVELS (NUM_LEVELS),
            .NUM_EXPR   (NUM_EXPR),
            .NUM_DESC   (NUM_DESC),
            .NUM_SRC    (NUM_SRC),
            .DATA_W     (DATA_W)
        ) u_eval (
            .src_flat (src_flat),
            .lvl_en   (lvl_en)
        );

        pfm_prio_pick #(
            .NUM_LEVELS (NUM_LEVELS),
            .SEL_W      (SEL_W)
        ) u_pick (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_en (lvl_en),
            .sel_q  (sel_o[p*SEL_W +: SEL_W])
        );
    end

endmodule

// File: rtl/pin_func_mux_chk.sv
module pin_func_mux_chk #(
    parameter int NUM_PINS   = 4,
    parameter int NUM_LEVELS = 5,
    parameter int NUM_REGS   = 3,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int SEL_W      = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [DATA_W-1:0]                wr_data,
    input logic [(NUM_REGS+1)*DATA_W-1:0]   src_flat,
    input logic                             strap_locked,
    input logic [NUM_PINS*SEL_W-1:0]        sel_o
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_wr
        // R2: a write lands in the addressed control register
        p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(r)) |=> (src_flat[r*DATA_W +: DATA_W] == $past(wr_data)));
    end

    // R3: the captured strap word is frozen once the sequencer holds
    p_strap_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strap_locked |=> $stable(src_flat[NUM_REGS*DATA_W +: DATA_W]));

    // R1: the sequencer never leaves ST_HOLD until reset
    p_hold_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strap_locked |=> strap_locked);

    // R4: outputs depend only on the registered source state
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(src_flat) |=> $stable(sel_o));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_rng
        // R5: no pin shows a code beyond the fallback
        p_sel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sel_o[p*SEL_W +: SEL_W] <= SEL_W'(NUM_LEVELS));
    end

endmodule

bind pin_func_mux pin_func_mux_chk #(
    .NUM_PINS   (NUM_PINS),
    .NUM_LEVELS (NUM_LEVELS),
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SEL_W      (SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .src_flat     (src_flat),
    .strap_locked (strap_locked),
    .sel_o        (sel_o)
);

// File: tb/pin_func_mux_bench.sv
`timescale 1ns/1ps
module pin_func_mux_bench;

    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] strap_i = '0;
    logic [11:0] sel_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m0, m1, m2, mst;

    always #5 clk = ~clk;

    pin_func_mux u_pin_func_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .strap_i(strap_i), .sel_o(sel_o)
    );

    function automatic logic [2:0] exp_sel(int p);
        logic a;
        case (p)
            0: begin
                a = m0[3] & m1[15];
                if (a && !m2[31])     return 3'd0;
                else if (a && m2[31]) return 3'd1;
                else                  return 3'd5;
            end
            1: return (m1[12] || mst[14]) ? 3'd0 : 3'd5;
            2: begin
                if (m2[5:4] != 2'd0 && m1[17]) return 3'd0;
                else if (m1[17])               return 3'd1;
                else                           return 3'd5;
            end
            default: begin
                if (m0[0])                         return 3'd0;
                else if (m0[1])                    return 3'd1;
                else if (m2[5:4] == 2'd3 && m1[22]) return 3'd2;
                else if (m1[22])                   return 3'd3;
                else if (!mst[6] && m0[2])         return 3'd4;
                else                               return 3'd5;
            end
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_pins(string tag);
        for (int p = 0; p < NP; p++)
            check($sformatf("%s pin%0d", tag, p), 32'(sel_o[p*3 +: 3]), 32'(exp_sel(p)));
    endtask

    task automatic read_chk(string tag, logic [1:0] a, logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    // R4: old selection after one edge, new selection after two
    task automatic do_write(logic [1:0] a, logic [31:0] d, string tag);
        logic [2:0] old_sel [NP];
        for (int p = 0; p < NP; p++) old_sel[p] = exp_sel(p);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int p = 0; p < NP; p++)
            check($sformatf("R4 latency pin%0d", p), 32'(sel_o[p*3 +: 3]), 32'(old_sel[p]));
        case (a)
            2'd0: m0 = d;
            2'd1: m1 = d;
            2'd2: m2 = d;
            default: ;
        endcase
        @(negedge clk);
        check_pins(tag);
    endtask

    task automatic do_reset(logic [31:0] st);
        rst_n = 1'b0;
        strap_i = st;
        m0 = '0; m1 = '0; m2 = '0; mst = st;
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++)
            check("R1 reset fallback", 32'(sel_o[p*3 +: 3]), 32'd5);
        read_chk("R1 ctrl0 zero", 2'd0, 32'd0);
        read_chk("R1 ctrl2 zero", 2'd2, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        read_chk("R3 strap captured", 2'd3, st);
        check_pins("R1 R7 post-reset");
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'd12345));

        // phase A: strap bit 14 set, bit 6 clear
        do_reset(32'h0000_4000);

        strap_i = 32'hFFFF_BFBF;
        @(negedge clk);
        read_chk("R3 strap input ignored", 2'd3, 32'h0000_4000);
        do_write(2'd3, 32'h0000_0000, "R3 strap write ignored");
        read_chk("R3 strap after write", 2'd3, 32'h0000_4000);

        do_write(2'd1, 32'hA5A5_0F0F, "R2 write ctrl1");
        read_chk("R2 readback ctrl1", 2'd1, 32'hA5A5_0F0F);
        do_write(2'd1, 32'h0000_0000, "R2 clear ctrl1");

        // R6: AND with a must-be-zero bit
        do_write(2'd0, 32'h0000_0008, "R6 one bit");
        do_write(2'd1, 32'h0000_8000, "R6 level0");
        do_write(2'd2, 32'h8000_0000, "R6 level1");
        do_write(2'd0, 32'h0000_0000, "R6 fallback");

        // R8: mode field sweep with shared enable
        do_write(2'd1, 32'h0002_0000, "R8 enable only");
        for (int v = 0; v < 4; v++)
            do_write(2'd2, 32'(v) << 4, $sformatf("R8 mode %0d", v));
        do_write(2'd1, 32'h0000_0000, "R8 enable off");

        // R9 / R5: everything enabled at once, then peel levels off
        do_write(2'd2, 32'h0000_0030, "R9 mode 3");
        do_write(2'd1, 32'h0042_9000, "R5 R9 ctrl1 all");
        do_write(2'd0, 32'h0000_000F, "R5 R9 all levels");
        do_write(2'd0, 32'h0000_000E, "R9 drop l0");
        do_write(2'd0, 32'h0000_000C, "R9 drop l1");
        do_write(2'd2, 32'h0000_0020, "R9 drop l2");
        do_write(2'd1, 32'h0000_8000, "R9 drop l3");
        do_write(2'd0, 32'h0000_0000, "R9 drop l4");

        for (int i = 0; i < 300; i++)
            do_write(2'($urandom_range(0, 3)), $urandom(), "R5 random A");

        // phase B: strap bit 14 clear, bit 6 set
        do_reset(32'h0000_0040);
        do_write(2'd1, 32'h0000_0000, "R7 both false");
        do_write(2'd1, 32'h0000_1000, "R7 ctrl bit");
        do_write(2'd0, 32'h0000_0004, "R9 strap blocks l4");
        for (int i = 0; i < 300; i++)
            do_write(2'($urandom_range(0, 3)), $urandom(), "R5 random B");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule